// File: doc/BRIEF.md
# Bus-Controlled GPIO Bank with Masked Update

This block is a Wishbone classic slave that drives a bank of general-purpose pins. The bus data width equals the pin count and is set by one parameter, `WIDTH`, which defaults to 8. Each pin has its own direction bit. A pin set as an output drives the stored output level. A pin set as an input releases its driver to high impedance. The pad is modelled as three signals per pin: an output value, an output enable and a sampled input.

Software reaches four word-addressed registers through a 2-bit address. The first sets the output levels. The second sets the direction. The third holds a write mask. The fourth is an update port: a write to it changes only the output bits whose mask bit is set. Setting the mask once lets single pins be changed without a read-modify-write of the whole output register.

Every strobed access is acknowledged in the same cycle. The slave never signals an error, a retry or a stall, so strobes can follow each other on consecutive cycles.

Top module: `gpio_bank_slave`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pin_out` and `pin_oe` are all zero. A read of address 1 or address 2 after reset returns zero.
- R2: A write to address 0 loads `bus_wdata` into the output register. `pin_out` shows the new value from the next clock edge.
- R3: A read of address 0 returns the level on each pin. For bit i this is `pin_out[i]` if `pin_oe[i]` is 1, and `pin_in[i]` if `pin_oe[i]` is 0.
- R4: A write to address 1 loads the direction register. A 1 bit makes the pin an output and a 0 bit makes it an input. `pin_oe` shows the value from the next edge, and a read of address 1 returns it.
- R5: A write to address 2 loads the mask register, and a read of address 2 returns the stored mask. A mask write leaves `pin_out` and `pin_oe` unchanged.
- R6: A write to address 3 sets the output register to `(out & ~mask) | (bus_wdata & mask)`. It leaves the mask and the direction unchanged.
- R7: A read of address 3 returns zero.
- R8: A register changes only in a cycle where `bus_cyc`, `bus_stb` and `bus_we` are all high. If any of the three is low, no register changes.
- R9: `bus_ack` equals `bus_cyc & bus_stb` in the same cycle, so it stays high for as long as the strobe stays high.
- R10: `bus_err`, `bus_rty` and `bus_stall` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | 2 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data |
| bus_ack | output | 1 | Acknowledge |
| bus_err | output | 1 | Error, tied low |
| bus_rty | output | 1 | Retry, tied low |
| bus_stall | output | 1 | Stall, tied low |
| pin_out | output | WIDTH | Output value per pin |
| pin_oe | output | WIDTH | Output enable per pin |
| pin_in | input | WIDTH | Sampled input per pin |

## Verification
The output and direction registers drive `pin_out` and `pin_oe` directly. A wrong value in either appears at the pins one edge after the faulty write, and the bench compares both pins on every cycle. The mask register has no pin of its own. A corrupted mask therefore shows up only through an address-2 readback, or through the pins after the next update write. For this reason the bench interleaves mask reads and update writes. A wrong pin-level mux appears combinationally on the same-cycle read of address 0. The bench varies `pin_in` so that both mux sources are exercised.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned GB_ADDR_W = 2;

   typedef enum logic [GB_ADDR_W-1:0] {
      GB_REG_LEVEL = 2'd0,
      GB_REG_DIR   = 2'd1,
      GB_REG_MASK  = 2'd2,
      GB_REG_UPD   = 2'd3
   } gb_reg_e;

   typedef struct packed {
      logic level;
      logic dir;
      logic mask;
      logic upd;
   } gb_wr_t;

endpackage

// File: rtl/gpio_bus_front.sv
module gpio_bus_front
   import gpio_bank_pkg::*;
(
   input  logic                 cyc,
   input  logic                 stb,
   input  logic                 we,
   input  logic [GB_ADDR_W-1:0] adr,
   output logic                 ack,
   output gb_wr_t               wr
);

   logic access;
   logic wr_any;

   assign access = cyc & stb;
   assign wr_any = access & we;
   assign ack    = access;

   always_comb begin
      wr = '0;
      if (wr_any) begin
         unique case (gb_reg_e'(adr))
            GB_REG_LEVEL: wr.level = 1'b1;
            GB_REG_DIR:   wr.dir   = 1'b1;
            GB_REG_MASK:  wr.mask  = 1'b1;
            GB_REG_UPD:   wr.upd   = 1'b1;
            default:      wr       = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter logic [WIDTH-1:0] OUT_RST  = '0,
   parameter logic [WIDTH-1:0] DIR_RST  = '0,
   parameter logic [WIDTH-1:0] MASK_RST = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  gb_wr_t           wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] mask_q
);

   logic [WIDTH-1:0] out_d;

   always_comb begin
      out_d = out_q;
      if (wr.level)
         out_d = wdata;
      else if (wr.upd)
         out_d = (out_q & ~mask_q) | (wdata & mask_q);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q  <= OUT_RST;
         dir_q  <= DIR_RST;
         mask_q <= MASK_RST;
      end else begin
         out_q <= out_d;
         if (wr.dir)  dir_q  <= wdata;
         if (wr.mask) mask_q <= wdata;
      end
   end

endmodule

// File: rtl/gpio_pad_model.sv
module gpio_pad_model #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] out_v,
   input  logic [WIDTH-1:0] oe_v,
   input  logic [WIDTH-1:0] in_v,
   output logic [WIDTH-1:0] level
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign level[i] = oe_v[i] ? out_v[i] : in_v[i];
   end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [GB_ADDR_W-1:0] adr,
   input  logic [WIDTH-1:0]     level,
   input  logic [WIDTH-1:0]     dir_q,
   input  logic [WIDTH-1:0]     mask_q,
   output logic [WIDTH-1:0]     rdata
);

   always_comb begin
      unique case (gb_reg_e'(adr))
         GB_REG_LEVEL: rdata = level;
         GB_REG_DIR:   rdata = dir_q;
         GB_REG_MASK:  rdata = mask_q;
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_bank_slave.sv
module gpio_bank_slave
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 bus_cyc,
   input  logic                 bus_stb,
   input  logic                 bus_we,
   input  logic [GB_ADDR_W-1:0] bus_adr,
   input  logic [WIDTH-1:0]     bus_wdata,
   output logic [WIDTH-1:0]     bus_rdata,
   output logic                 bus_ack,
   output logic                 bus_err,
   output logic                 bus_rty,
   output logic                 bus_stall,
   output logic [WIDTH-1:0]     pin_out,
   output logic [WIDTH-1:0]     pin_oe,
   input  logic [WIDTH-1:0]     pin_in
);

   localparam int unsigned MAX_WIDTH = 64;

   if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_width_bad
      $error("gpio_bank_slave: WIDTH must lie in 1..64");
   end

   gb_wr_t           wr;
   logic [WIDTH-1:0] out_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] level;

   gpio_bus_front u_front (
      .cyc (bus_cyc),
      .stb (bus_stb),
      .we  (bus_we),
      .adr (bus_adr),
      .ack (bus_ack),
      .wr  (wr)
   );

   gpio_reg_bank #(.WIDTH(WIDTH)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr),
      .wdata  (bus_wdata),
      .out_q  (out_q),
      .dir_q  (dir_q),
      .mask_q (mask_q)
   );

   gpio_pad_model #(.WIDTH(WIDTH)) u_pads (
      .out_v (out_q),
      .oe_v  (dir_q),
      .in_v  (pin_in),
      .level (level)
   );

   gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
      .adr    (bus_adr),
      .level  (level),
      .dir_q  (dir_q),
      .mask_q (mask_q),
      .rdata  (bus_rdata)
   );

   assign pin_out   = out_q;
   assign pin_oe    = dir_q;
   assign bus_err   = 1'b0;
   assign bus_rty   = 1'b0;
   assign bus_stall = 1'b0;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             cyc,
   input logic             stb,
   input logic             we,
   input logic [1:0]       adr,
   input logic [WIDTH-1:0] wdata,
   input logic [WIDTH-1:0] rdata,
   input logic             ack,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] mask_q
);

   logic wr_cyc;
   logic rd_cyc;
   assign wr_cyc = cyc && stb && we;
   assign rd_cyc = cyc && stb && !we;

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (pin_out == '0 && pin_oe == '0)); // R1

   AST_LEVEL_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_cyc && adr == 2'd0) |=> pin_out == $past(wdata)); // R2

   AST_PIN_READBACK: assert property (@(posedge clk) disable iff (rst)
      (rd_cyc && adr == 2'd0) |-> rdata == ((pin_out & pin_oe) | (pin_in & ~pin_oe))); // R3

   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_cyc && adr == 2'd1) |=> pin_oe == $past(wdata)); // R4

   AST_MASK_WRITE_PINS: assert property (@(posedge clk) disable iff (rst)
      (wr_cyc && adr == 2'd2) |=> ($stable(pin_out) && $stable(pin_oe))); // R5

   AST_MASKED_UPDATE: assert property (@(posedge clk) disable iff (rst)
      (wr_cyc && adr == 2'd3) |=>
         pin_out == (($past(pin_out) & ~$past(mask_q)) | ($past(wdata) & $past(mask_q)))); // R6

   AST_UPD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_cyc && adr == 2'd3) |-> rdata == '0); // R7

   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_cyc |=> ($stable(pin_out) && $stable(pin_oe) && $stable(mask_q))); // R8

   AST_ACK_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      (cyc && stb) |-> ack); // R9

   AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      !(cyc && stb) |-> !ack); // R9

endmodule

bind gpio_bank_slave gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .cyc     (bus_cyc),
   .stb     (bus_stb),
   .we      (bus_we),
   .adr     (bus_adr),
   .wdata   (bus_wdata),
   .rdata   (bus_rdata),
   .ack     (bus_ack),
   .pin_out (pin_out),
   .pin_oe  (pin_oe),
   .pin_in  (pin_in),
   .mask_q  (mask_q)
);

// File: tb/sim_gpio_bank_slave.sv
`timescale 1ns/1ps
module sim_gpio_bank_slave;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [1:0]   adr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         ack, err, rty, stall;
   logic [W-1:0] pin_out, pin_oe;
   logic [W-1:0] pin_in = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [W-1:0] m_out = '0, m_dir = '0, m_mask = '0;
   logic [15:0]  lfsr = 16'hACE1;

   always #5 clk = ~clk;

   gpio_bank_slave #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst),
      .bus_cyc(cyc), .bus_stb(stb), .bus_we(we), .bus_adr(adr),
      .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack),
      .bus_err(err), .bus_rty(rty), .bus_stall(stall),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return (m_out & m_dir) | (pin_in & ~m_dir);
         2'd1:    return m_dir;
         2'd2:    return m_mask;
         default: return '0;
      endcase
   endfunction

   // One bus cycle: drive at negedge, compare everything, then advance the model.
   task automatic step(input logic c, input logic s, input logic w,
                       input logic [1:0] a, input logic [W-1:0] d,
                       input logic [W-1:0] pins);
      @(negedge clk);
      cyc = c; stb = s; we = w; adr = a; wdata = d; pin_in = pins;
      #1;
      check("R9", "ack", 32'(ack), 32'(c & s));
      check("R10", "err/rty/stall", {29'd0, err, rty, stall}, 32'd0);
      check("R2 R6 R8", "pin_out", 32'(pin_out), 32'(m_out));
      check("R4 R8", "pin_oe", 32'(pin_oe), 32'(m_dir));
      case (a)
         2'd0: check("R3", "rdata level", 32'(rdata), 32'(exp_read(a)));
         2'd1: check("R4", "rdata dir", 32'(rdata), 32'(exp_read(a)));
         2'd2: check("R5", "rdata mask", 32'(rdata), 32'(exp_read(a)));
         default: check("R7", "rdata upd", 32'(rdata), 32'(exp_read(a)));
      endcase
      @(posedge clk);
      if (c && s && w) begin
         case (a)
            2'd0: m_out = d;
            2'd1: m_dir = d;
            2'd2: m_mask = d;
            default: m_out = (m_out & ~m_mask) | (d & m_mask);
         endcase
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      step(1'b1, 1'b1, 1'b1, a, d, pin_in);
   endtask

   task automatic rd(input logic [1:0] a, input logic [W-1:0] pins);
      step(1'b1, 1'b1, 1'b0, a, '0, pins);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "pin_out in reset", 32'(pin_out), 32'd0);
      check("R1", "pin_oe in reset", 32'(pin_oe), 32'd0);
      rst = 1'b0;
      // R1: state after reset, read back through the bus
      rd(2'd1, 8'h00);
      rd(2'd2, 8'h00);
      rd(2'd0, 8'h5A);
      // R4 / R2 / R3
      wr(2'd1, 8'hF0);
      wr(2'd0, 8'hA5);
      rd(2'd0, 8'h3C);
      rd(2'd0, 8'hC3);
      rd(2'd1, 8'h00);
      // R5 / R6 / R7
      wr(2'd2, 8'h0F);
      rd(2'd2, 8'h00);
      wr(2'd3, 8'hFF);
      rd(2'd3, 8'hFF);
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h00);
      wr(2'd2, 8'hFF);
      wr(2'd3, 8'h12);
      wr(2'd2, 8'h81);
      wr(2'd3, 8'h7E);
      // R8: each qualifier low in turn
      step(1'b0, 1'b1, 1'b1, 2'd0, 8'hFF, 8'h00);
      step(1'b1, 1'b0, 1'b1, 2'd1, 8'h00, 8'h00);
      step(1'b1, 1'b1, 1'b0, 2'd3, 8'hFF, 8'h00);
      step(1'b0, 1'b0, 1'b1, 2'd2, 8'hAA, 8'h00);
      rd(2'd2, 8'h00);
      // R9: back-to-back strobes keep ack high
      for (int i = 0; i < 4; i++) rd(2'(i), 8'h99);
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[5], lfsr[1] | lfsr[6], lfsr[2], lfsr[4:3],
              lfsr[15:8], lfsr[11:4]);
      end
      // R1: reset mid-run clears the pins
      @(negedge clk);
      cyc = 1'b0; stb = 1'b0; rst = 1'b1;
      @(negedge clk);
      check("R1", "pin_out after reset", 32'(pin_out), 32'd0);
      check("R1", "pin_oe after reset", 32'(pin_oe), 32'd0);
      rst = 1'b0;
      m_out = '0; m_dir = '0; m_mask = '0;
      rd(2'd2, 8'h00);
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule